// File: doc/BRIEF.md
# Parallel Interference Cancellation Stage

This block is one stage of a cascaded multiuser detector for up to eight synchronous CDMA users. A stage is given the matched-filter output of every user, the hard decisions of the stage before it, and a cross-correlation matrix loaded beforehand. It removes the interference that the other users' decisions predict, and it produces new soft and hard decisions. Three stages in a row form a three-stage detector. The first stage is built with `FIRST=1`. It forms its starting decisions from the signs of the matched-filter outputs. Every stage forwards the matched-filter values it captured, so the next stage receives them alongside the decisions.

The stage does not multiply. While it captures a new frame, it recodes each user's decision into one of five column operations: skip, add, subtract, add twice, or subtract twice. After that it visits one matrix column per clock and updates all per-user interference accumulators in parallel. The accumulators hold their values from one frame to the next. A later frame therefore applies only the change in decisions: a decision that flipped contributes twice its matrix entry, and an unchanged one is skipped. A matrix load or a reset clears the held state, so the next frame rebuilds the interference from nothing.

Top module: `pic_stage`

## Requirements
- R1: A matrix write is accepted on a clock edge where `ld_valid` and `ld_ready` are both high. It stores `ld_data` as entry (row = `ld_addr` / N, column = `ld_addr` % N). `ld_ready` is low for as long as a frame is in progress, and writes offered during that time are lost.
- R2: A frame is accepted on an edge where `st_valid` and `st_ready` are both high. `st_ready` then stays low until the frame finishes. `done` is high for exactly one cycle: the cycle that follows the (N+1)-th rising edge after the accepting edge.
- R3: At `done`, soft output k equals y_k − Σ_{j≠k} C[k][j]·d_j, saturated to the range −2048..2047. The decision d_j is +1 when its bit is 0 and −1 when its bit is 1. The soft output is a 12-bit signed value in bits [12k+11:12k].
- R4: Diagonal matrix entries C[k][k] have no effect on any output.
- R5: Hard output bit k is 1 exactly when soft output k is negative. A soft value of zero gives bit 0, meaning +1.
- R6: With `FIRST=1`, the stage ignores `dec_in`. It uses d_j = −1 when y_j < 0 and d_j = +1 otherwise.
- R7: Without a reload between frames, consecutive frames with changing decisions each still meet R3 exactly.
- R8: After a new matrix load, the next frame meets R3 for the new matrix. No interference from the old matrix remains.
- R9: From `done` onward, `y_out` holds the `y_in` captured at the accepting edge.
- R10: After reset, `done` is low, both ready outputs are high, and the soft and hard outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Matrix write offered |
| ld_ready | output | 1 | Stage can take a matrix write |
| ld_addr | input | 6 | Entry index, row·N + column |
| ld_data | input | 12 | Signed matrix entry |
| st_valid | input | 1 | Frame start offered |
| st_ready | output | 1 | Stage idle, can start a frame |
| y_in | input | 96 | Matched-filter outputs, 12 bits per user |
| dec_in | input | 8 | Previous-stage decisions, 1 = −1 |
| y_out | output | 96 | Captured matched-filter outputs for the next stage |
| soft_out | output | 96 | Soft decisions, 12 bits per user |
| hard_out | output | 8 | Hard decisions, 1 = −1 |
| done | output | 1 | One-cycle pulse: results ready |

## Verification
The assertions assume that `st_valid` is offered only through the handshake. They also assume that the outputs change only on the `done` edge, which means nothing outside the stage writes to them. The bench drives all inputs on the falling edge. It raises `st_valid` only while `st_ready` is high and drops it right after acceptance. It picks matrix entries so that the exact interference sum fits the accumulator. Those sums run up to several thousand in magnitude and reach the saturation limits only on purpose.

// File: rtl/pic_stage.sv
module pic_stage #(
  parameter int N = 8,
  parameter int W = 12,
  parameter bit FIRST = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_valid,
  output logic                       ld_ready,
  input  logic [$clog2(N*N)-1:0]     ld_addr,
  input  logic signed [W-1:0]        ld_data,
  input  logic                       st_valid,
  output logic                       st_ready,
  input  logic [N*W-1:0]             y_in,
  input  logic [N-1:0]               dec_in,
  output logic [N*W-1:0]             y_out,
  output logic [N*W-1:0]             soft_out,
  output logic [N-1:0]               hard_out,
  output logic                       done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int AW = W + $clog2(N) + 2;
  localparam logic signed [AW:0] SMAX = (AW+1)'((1 <<< (W-1)) - 1);
  localparam logic signed [AW:0] SMIN = -(AW+1)'(1 <<< (W-1));

  typedef enum logic [1:0] {IDLE, SCAN, FIN} st_t;
  typedef enum logic [2:0] {OP_SKIP, OP_ADD1, OP_SUB1, OP_ADD2, OP_SUB2} op_t;

  st_t state;
  logic [IW-1:0] idx;
  logic signed [W-1:0] cmat [N*N];
  logic signed [AW-1:0] acc [N];
  logic signed [AW-1:0] nxt [N];
  op_t rec [N];
  op_t rec_new [N];
  logic [N-1:0] dref, dnew, ysgn;
  logic have_ref, fullv;

  assign st_ready = (state == IDLE);
  assign ld_ready = (state == IDLE);

  wire ld_acc = ld_valid && ld_ready;
  wire accept = st_valid && st_ready;

  always_comb
    for (int k = 0; k < N; k++) ysgn[k] = y_in[k*W + W - 1];

  assign dnew  = FIRST ? ysgn : dec_in;
  assign fullv = FIRST || !have_ref || ld_acc;

  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (fullv)                rec_new[j] = dnew[j] ? OP_SUB1 : OP_ADD1;
      else if (dnew[j] == dref[j]) rec_new[j] = OP_SKIP;
      else                      rec_new[j] = dnew[j] ? OP_SUB2 : OP_ADD2;
    end
  end

  always_comb begin
    for (int k = 0; k < N; k++) begin
      logic signed [AW-1:0] e;
      e = AW'(cmat[k*N + int'(idx)]);
      nxt[k] = acc[k];
      if (k != int'(idx)) begin
        case (rec[idx])
          OP_ADD1: nxt[k] = acc[k] + e;
          OP_SUB1: nxt[k] = acc[k] - e;
          OP_ADD2: nxt[k] = acc[k] + (e <<< 1);
          OP_SUB2: nxt[k] = acc[k] - (e <<< 1);
          default: nxt[k] = acc[k];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N*N; i++) cmat[i] <= '0;
    end else if (ld_acc) begin
      cmat[ld_addr] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      idx      <= '0;
      dref     <= '0;
      have_ref <= 1'b0;
      y_out    <= '0;
      soft_out <= '0;
      hard_out <= '0;
      done     <= 1'b0;
      for (int k = 0; k < N; k++) begin
        acc[k] <= '0;
        rec[k] <= OP_SKIP;
      end
    end else begin
      done <= 1'b0;
      if (ld_acc) begin
        have_ref <= 1'b0;
        for (int k = 0; k < N; k++) acc[k] <= '0;
      end
      case (state)
        IDLE: if (accept) begin
          y_out    <= y_in;
          dref     <= dnew;
          have_ref <= 1'b1;
          idx      <= '0;
          for (int k = 0; k < N; k++) begin
            rec[k] <= rec_new[k];
            if (fullv) acc[k] <= '0;
          end
          state <= SCAN;
        end
        SCAN: begin
          for (int k = 0; k < N; k++) acc[k] <= nxt[k];
          if (int'(idx) == N - 1) state <= FIN;
          else idx <= idx + 1'b1;
        end
        FIN: begin
          for (int k = 0; k < N; k++) begin
            logic signed [AW:0] d;
            logic signed [W-1:0] s;
            d = (AW+1)'($signed(y_out[k*W +: W])) - (AW+1)'(acc[k]);
            if (d > SMAX)      s = SMAX[W-1:0];
            else if (d < SMIN) s = SMIN[W-1:0];
            else               s = d[W-1:0];
            soft_out[k*W +: W] <= s;
            hard_out[k]        <= s[W-1];
          end
          done  <= 1'b1;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module pic_stage_chk #(
  parameter int N = 8,
  parameter int W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           st_valid,
  input logic           st_ready,
  input logic [N*W-1:0] soft_out,
  input logic [N-1:0]   hard_out,
  input logic           done
);
  int cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (st_valid && st_ready) cnt <= 1;
    else if (done) cnt <= 0;
    else if (cnt != 0) cnt <= cnt + 1;
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> !st_ready);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == N + 2);
  p_quiet_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(soft_out) && $stable(hard_out)));

  for (genvar k = 0; k < N; k++) begin : g_zero
    p_zero_plus_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && soft_out[k*W +: W] == '0) |-> !hard_out[k]);
  end
endmodule

bind pic_stage pic_stage_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .soft_out(soft_out), .hard_out(hard_out), .done(done)
);

// File: tb/pic_stage_test.sv
`timescale 1ns/1ps
module pic_stage_test;
  localparam int N = 8;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [5:0] ld_addr = '0;
  logic signed [W-1:0] ld_data = '0;
  logic st_valid = 1'b0;
  logic [N*W-1:0] y_in = '0;
  logic [N-1:0] dec_in = '0;
  logic ld_ready, st_ready, done, ld_ready_f, st_ready_f, done_f;
  logic [N*W-1:0] y_out, soft_out, y_out_f, soft_out_f;
  logic [N-1:0] hard_out, hard_out_f;

  always #2.5 clk = ~clk;

  pic_stage #(.N(N), .W(W), .FIRST(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .st_valid(st_valid), .st_ready(st_ready),
    .y_in(y_in), .dec_in(dec_in), .y_out(y_out), .soft_out(soft_out),
    .hard_out(hard_out), .done(done));

  pic_stage #(.N(N), .W(W), .FIRST(1'b1)) uut_first (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready_f),
    .ld_addr(ld_addr), .ld_data(ld_data), .st_valid(st_valid), .st_ready(st_ready_f),
    .y_in(y_in), .dec_in(dec_in), .y_out(y_out_f), .soft_out(soft_out_f),
    .hard_out(hard_out_f), .done(done_f));

  int tests = 0, fails = 0;
  int cm [N][N];
  int yv [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int expect_soft(input int k, input logic [N-1:0] d);
    int s = yv[k];
    for (int j = 0; j < N; j++)
      if (j != k) s -= cm[k][j] * (d[j] ? -1 : 1);
    return sat(s);
  endfunction

  task automatic load_mat();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 6'(r*N + c); ld_data = W'(cm[r][c]);
        @(posedge clk);
      end
    @(negedge clk) ld_valid = 1'b0;
  endtask

  task automatic fill_mat(input int s, input int span);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        cm[r][c] = ((r*37 + c*11 + s*13) % (2*span+1)) - span;
  endtask

  task automatic run_frame(input string tag, input logic [N-1:0] d, input bit busy_write);
    int n;
    logic [N-1:0] ds;
    @(negedge clk);
    for (int k = 0; k < N; k++) y_in[k*W +: W] = W'(yv[k]);
    dec_in = d; st_valid = 1'b1;
    @(posedge clk);
    @(negedge clk) st_valid = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      if (busy_write && n == 3) begin
        chk(ld_ready == 1'b0, {tag, " R1 ld_ready busy"}, int'(ld_ready), 0);
        ld_valid = 1'b1; ld_addr = 6'd1; ld_data = 12'sd777;
      end
      @(negedge clk); n++;
      ld_valid = 1'b0;
    end
    chk(n == N + 2, {tag, " R2 latency"}, n, N + 2);
    for (int k = 0; k < N; k++) ds[k] = (yv[k] < 0);
    for (int k = 0; k < N; k++) begin
      int e = expect_soft(k, d);
      int ef = expect_soft(k, ds);
      int a = int'($signed(soft_out[k*W +: W]));
      int af = int'($signed(soft_out_f[k*W +: W]));
      chk(a == e, {tag, " R3 soft"}, a, e);
      chk(hard_out[k] == (e < 0), {tag, " R5 hard"}, int'(hard_out[k]), int'(e < 0));
      chk(af == ef, {tag, " R6 first-stage soft"}, af, ef);
      chk(int'($signed(y_out[k*W +: W])) == yv[k], {tag, " R9 y_out"},
          int'($signed(y_out[k*W +: W])), yv[k]);
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R2 done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk(done == 0, "R10 done", int'(done), 0);
    chk(st_ready == 1 && ld_ready == 1, "R10 ready", int'(st_ready), 1);
    chk(soft_out == '0 && hard_out == '0, "R10 outputs", int'(soft_out[11:0]), 0);
  endtask

  task automatic t_basic();
    fill_mat(1, 120); load_mat();
    for (int k = 0; k < N; k++) yv[k] = (k*311 % 1500) - 700;
    run_frame("basic", 8'b1010_0110, 1'b0);
  endtask

  task automatic t_diff_r7();
    run_frame("diff1 R7", 8'b0101_1001, 1'b0);
    run_frame("diff2 R7", 8'b0101_1000, 1'b0);
    run_frame("diff3 R7", 8'b0101_1000, 1'b0);
    run_frame("diff4 R7", 8'b1111_1111, 1'b0);
  endtask

  task automatic t_diag_r4();
    for (int k = 0; k < N; k++) cm[k][k] = (k % 2) ? 2000 : -2000;
    load_mat();
    run_frame("diag R4", 8'b0011_1100, 1'b0);
  endtask

  task automatic t_reload_r8();
    fill_mat(5, 90); load_mat();
    for (int k = 0; k < N; k++) yv[k] = 400 - k*97;
    run_frame("reload R8", 8'b1100_0011, 1'b0);
  endtask

  task automatic t_busy_r1();
    run_frame("busy R1", 8'b0000_1111, 1'b1);
    run_frame("after busy R1", 8'b0000_1111, 1'b0);
  endtask

  task automatic t_sat_r3();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) cm[r][c] = (r < 4) ? -1500 : 1500;
    load_mat();
    for (int k = 0; k < N; k++) yv[k] = (k < 4) ? 2047 : -2048;
    run_frame("sat R3", 8'h00, 1'b0);
  endtask

  task automatic t_zero_r5();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) cm[r][c] = 0;
    load_mat();
    for (int k = 0; k < N; k++) yv[k] = (k % 3 == 0) ? 0 : ((k % 3 == 1) ? -5 : 9);
    run_frame("zero R5", 8'h5a, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_diff_r7();
    t_diag_r4();
    t_reload_r8();
    t_busy_r1();
    t_sat_r3();
    t_zero_r5();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule